// File: doc/BRIEF.md
# Cross-Bank Gap Checker for Auto-Precharge Accesses

This block watches a DDR2-style command stream and enforces the shortest legal spacing between a read or write that carries auto precharge on one bank and a later command aimed at a different bank. It remembers the most recent auto-precharge access, whether it was a read or a write, and its bank. It also counts the clocks since that access was registered.

Two outputs come from that state. A combinational `q_ok` answers, for a candidate command and bank placed on the query inputs, whether that command may issue in the current cycle. A registered `violation` pulses for one cycle after a command is registered earlier than its gap allows. The gap depends on the kind of the source command and the kind of the target command, so the table is not symmetric. The write-to-read entry also includes the CAS latency and the write-to-read turnaround. Burst length, CAS latency and turnaround are configuration inputs given in clocks.

Top module: `apc_xbank_gap`

## Requirements
- R1: Command codes are 0 idle, 1 ACTIVATE, 2 PRECHARGE, 3 READ, 4 READ with auto precharge, 5 WRITE, 6 WRITE with auto precharge, and 7 is treated as idle. After reset nothing is tracked, `q_ok` is 1 for every query and `violation` is 0.
- R2: After a WRITE with auto precharge, a READ or READ with auto precharge to another bank is allowed only once the clocks since the write reach (max(CL,1) − 1) + BL/2 + T, where T is the turnaround term defined in R11.
- R3: After a WRITE with auto precharge, a WRITE or WRITE with auto precharge to another bank needs BL/2 clocks.
- R4: After a READ with auto precharge, a READ or READ with auto precharge to another bank needs BL/2 clocks.
- R5: After a READ with auto precharge, a WRITE or WRITE with auto precharge to another bank needs BL/2 + 2 clocks.
- R6: ACTIVATE and PRECHARGE to another bank need 1 clock, so they are allowed in every cycle after the tracked access.
- R7: A query is allowed when nothing is tracked, when it targets the tracked bank, or when its code is idle.
- R8: When `cmd_valid` registers a command that `q_ok` would refuse, `violation` is 1 in the following cycle only. Otherwise it is 0.
- R9: Each newly registered auto-precharge access replaces the tracked source, kind and bank, and restarts the clock count at 1 in the next cycle.
- R10: `cfg_err` is 1 whenever `cfg_bl` is neither 4 nor 8.
- R11: The turnaround term T is `cfg_twtr` clocks, but never less than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is registered this cycle |
| cmd_kind | input | 3 | Code of the registered command (R1) |
| cmd_bank | input | BANK_W | Bank of the registered command |
| cfg_cl | input | CFG_W | CAS latency in clocks |
| cfg_bl | input | CFG_W | Burst length, 4 or 8 |
| cfg_twtr | input | CFG_W | Write-to-read turnaround in clocks |
| q_kind | input | 3 | Code of the candidate command |
| q_bank | input | BANK_W | Bank of the candidate command |
| q_ok | output | 1 | Candidate may issue this cycle |
| violation | output | 1 | Previous-cycle command was too early |
| cfg_err | output | 1 | Unsupported burst length |

## Verification
The bench builds the block with BANK_W = 2 so that same-bank commands, which are always allowed, come up often. It keeps CNT_W = 6, so long idle gaps push the counter into saturation, and that level still lies above the largest possible gap. CFG_W = 4 allows CL up to 15 and a turnaround of 0 or 1, which reach the 33-clock write-to-read gap and the floor of 2 on the turnaround term. Random traffic at several configurations, including CL = 0 and an illegal burst length, is compared every cycle against a behavioural model. A short directed sequence checks that a second auto-precharge access replaces the first.

// File: rtl/apc_xbank_gap.sv
module apc_xbank_gap #(
  parameter int BANK_W = 3,
  parameter int CFG_W  = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [CFG_W-1:0]  cfg_cl,
  input  logic [CFG_W-1:0]  cfg_bl,
  input  logic [CFG_W-1:0]  cfg_twtr,
  input  logic [2:0]        q_kind,
  input  logic [BANK_W-1:0] q_bank,
  output logic              q_ok,
  output logic              violation,
  output logic              cfg_err
);
  localparam int NW = CFG_W + 2;
  localparam int CW = ((NW > CNT_W) ? NW : CNT_W) + 1;
  localparam logic [2:0] K_ACT = 3'd1, K_PRE = 3'd2, K_RD = 3'd3, K_RDA = 3'd4,
                         K_WR = 3'd5, K_WRA = 3'd6;

  logic              pend, src_wr;
  logic [BANK_W-1:0] src_bank;
  logic [CNT_W-1:0]  cnt;
  logic [NW-1:0]     half, turn, cl1;
  logic              cmd_ok, cmd_apc;

  assign half = NW'(cfg_bl >> 1);
  assign turn = (cfg_twtr < CFG_W'(2)) ? NW'(2) : NW'(cfg_twtr);
  assign cl1  = (cfg_cl == '0) ? '0 : NW'(cfg_cl) - NW'(1);

  function automatic logic [NW-1:0] gap(input logic wr_src, input logic [2:0] k,
                                        input logic [NW-1:0] h, input logic [NW-1:0] t,
                                        input logic [NW-1:0] c);
    if (k == K_RD || k == K_RDA) gap = wr_src ? c + h + t : h;
    else if (k == K_WR || k == K_WRA) gap = wr_src ? h : h + NW'(2);
    else if (k == K_ACT || k == K_PRE) gap = NW'(1);
    else gap = '0;
  endfunction

  function automatic logic allowed(input logic [2:0] k, input logic [BANK_W-1:0] b);
    allowed = !pend || (b == src_bank) || (CW'(cnt) >= CW'(gap(src_wr, k, half, turn, cl1)));
  endfunction

  assign q_ok    = allowed(q_kind, q_bank);
  assign cmd_ok  = allowed(cmd_kind, cmd_bank);
  assign cmd_apc = cmd_valid && (cmd_kind == K_RDA || cmd_kind == K_WRA);
  assign cfg_err = !(cfg_bl == CFG_W'(4) || cfg_bl == CFG_W'(8));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      src_wr    <= 1'b0;
      src_bank  <= '0;
      cnt       <= '0;
      violation <= 1'b0;
    end else begin
      violation <= cmd_valid && !cmd_ok;
      if (cmd_apc) begin
        pend     <= 1'b1;
        src_wr   <= (cmd_kind == K_WRA);
        src_bank <= cmd_bank;
        cnt      <= CNT_W'(1);
      end else if (pend && cnt != '1) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  a_r6_act_pre_free: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == K_ACT || cmd_kind == K_PRE) |=> !violation);
  a_r7_same_bank_free: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && pend && cmd_bank == src_bank |=> !violation);
  a_r8_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !violation);
  a_r9_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !cmd_apc && cnt != '1 |=> cnt == $past(cnt) + CNT_W'(1));
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_apc |=> pend && cnt == CNT_W'(1) && src_bank == $past(cmd_bank));
  a_r10_bl_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bl == CFG_W'(4) || cfg_bl == CFG_W'(8)) |-> !cfg_err);
endmodule

// File: tb/apc_xbank_gap_tb.sv
module apc_xbank_gap_tb_top;
  localparam int BW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_kind = '0, q_kind = '0;
  logic [BW-1:0] cmd_bank = '0, q_bank = '0;
  logic [3:0] cfg_cl = 4'd5, cfg_bl = 4'd8, cfg_twtr = 4'd3;
  logic q_ok, violation, cfg_err;

  int total = 0, bad = 0;
  int m_pend = 0, m_wr = 0, m_bank = 0, m_age = 0, m_viol = 0;

  always #5 clk = ~clk;

  apc_xbank_gap #(.BANK_W(BW), .CFG_W(4), .CNT_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .cfg_twtr(cfg_twtr),
    .q_kind(q_kind), .q_bank(q_bank), .q_ok(q_ok), .violation(violation),
    .cfg_err(cfg_err));

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_gap(int k);
    int h = int'(cfg_bl) / 2;
    int t = (cfg_twtr < 2) ? 2 : int'(cfg_twtr);
    int c = (cfg_cl == 0) ? 0 : int'(cfg_cl) - 1;
    if (k == 3 || k == 4) return m_wr ? c + h + t : h;
    if (k == 5 || k == 6) return m_wr ? h : h + 2;
    if (k == 1 || k == 2) return 1;
    return 0;
  endfunction

  function automatic bit m_ok(int k, int b);
    return (m_pend == 0) || (b == m_bank) || (m_age >= m_gap(k));
  endfunction

  function automatic string tag_of(int k, int b);
    if (m_pend == 0 || b == m_bank || k == 0 || k == 7) return "R7";
    if (k == 1 || k == 2) return "R6";
    if (m_wr && (k == 3 || k == 4)) return (cfg_twtr < 2) ? "R11" : "R2";
    if (m_wr) return "R3";
    if (k == 3 || k == 4) return "R4";
    return "R5";
  endfunction

  task automatic step(input bit v, input int k, input int b, input int qk, input int qb);
    @(negedge clk);
    cmd_valid = v; cmd_kind = 3'(k); cmd_bank = BW'(b);
    q_kind = 3'(qk); q_bank = BW'(qb);
    #1;
    chk(violation, m_viol[0], "R8");
    chk(q_ok, m_ok(qk, qb), tag_of(qk, qb));
    chk(cfg_err, !(cfg_bl == 4 || cfg_bl == 8), "R10");
    m_viol = (v && !m_ok(k, b)) ? 1 : 0;
    if (v && (k == 4 || k == 6)) begin
      m_pend = 1; m_wr = (k == 6); m_bank = b; m_age = 0;
    end
    m_age++;
  endtask

  task automatic random_run(input int n, input int apc_pct, input int v_pct);
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(99);
      int k = $urandom_range(7);
      if (r < apc_pct) k = ($urandom_range(1) == 1) ? 6 : 4;
      step($urandom_range(99) < v_pct, k, $urandom_range(3),
           $urandom_range(7), $urandom_range(3));
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(q_ok, 1'b1, "R1");
        chk(violation, 1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        m_pend = 0; m_viol = 0;
        cfg_cl = 4'd5; cfg_bl = 4'd4; cfg_twtr = 4'd2;
        step(1, 4, 1, 3, 0);
        step(1, 6, 2, 3, 0);
        step(0, 0, 0, 3, 1);
        step(0, 0, 0, 3, 1);
        chk(q_ok, 1'b0, "R9");
        step(0, 0, 0, 3, 2);
        chk(q_ok, 1'b1, "R9");
        random_run(2000, 4, 40);
        cfg_cl = 4'd15; cfg_bl = 4'd8; cfg_twtr = 4'd15;
        random_run(2000, 3, 30);
        cfg_cl = 4'd0; cfg_bl = 4'd8; cfg_twtr = 4'd0;
        random_run(1500, 5, 50);
        cfg_cl = 4'd3; cfg_bl = 4'd4; cfg_twtr = 4'd1;
        random_run(1500, 8, 60);
        cfg_bl = 4'd6;
        random_run(300, 5, 40);
        cfg_bl = 4'd8;
        step(1, 6, 0, 0, 0);
        for (int i = 0; i < 80; i++) step(0, 0, 0, 3, 1);
        random_run(1000, 1, 20);
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule